// File: doc/BRIEF.md
# Sleep and Idle Power-Mode Controller

This block decides when a small processor core may stop its clocks and when it must start them again. A power-save request taken while the core is running selects one of two low-power modes. In the deep mode (Sleep) the core clock, the peripheral clocks and the oscillator are all switched off. In the light mode (Idle) only the core clock is gated, and the oscillator and peripherals keep running.

The block leaves either mode on any of three causes: an interrupt that is enabled and has a priority above the core's level, a watchdog time-out while the watchdog is enabled, or a warm reset (brown-out or external pin). Idle returns to Run on the next clock. Sleep first passes through a wait state with the oscillator switched on, and only returns to Run once the oscillator reports stable. An interrupt wake ends with a one-cycle pulse that tells the core to branch to its service routine.

Three sticky status flags record what happened: one flag for a Sleep exit, one for an Idle exit, and one for a watchdog wake. Software clears them with write-one-to-clear strobes. Power-on reset initialises the whole block.

Top module: `pwr_mode_ctl`

## Requirements
- R1: While `por` is high at a clock edge, the next state is Run: all three clock enables are 1, and `wake_isr` and all status flags are 0.
- R2: In Run, `save_req`=1 with `save_mode`=0 (Sleep) makes `cpu_clk_en`, `per_clk_en` and `osc_en` all 0 from the next cycle.
- R3: In Run, `save_req`=1 with `save_mode`=1 (Idle) makes `cpu_clk_en` 0 from the next cycle, while `per_clk_en` and `osc_en` stay 1.
- R4: A `save_req` taken outside Run is ignored, and the clock enables keep their values.
- R5: A source wakes the block only if its `irq_en` bit is 1, its `irq_pend` bit is 1, and its 3-bit priority field (source i at bits [3i+2:3i] of `irq_pri`) is strictly greater than `cpu_pri`. An interrupt wake sets the flag of the mode being left.
- R6: Pending sources that are disabled, or whose priority is at or below `cpu_pri`, leave the block in its low-power mode.
- R7: An Idle wake restores `cpu_clk_en` on the next cycle. A Sleep wake first enters a wait state with `osc_en`=1 and `cpu_clk_en`=0 and `per_clk_en`=0. It leaves the wait state on the cycle after `osc_stable` is seen high.
- R8: `wdt_to` with `wdt_en`=1 in either mode causes a wake that sets the mode flag and `st_wdto`, with no `wake_isr` pulse, even if an interrupt wake arrives in the same cycle. `wdt_to` with `wdt_en`=0 is ignored.
- R9: `bor` or `ext_rst` in any low-power state returns to Run on the next cycle, sets the flag of that mode and gives no `wake_isr`. In Run they leave the flags unchanged.
- R10: Status flags hold until their clear strobe. A strobe clears its flag on the next cycle, but a set in the same cycle wins over the clear.
- R11: `wake_isr` is a single-cycle pulse. It is high only in the first Run cycle after an interrupt wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running controller clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| bor | input | 1 | Brown-out reset event |
| ext_rst | input | 1 | External reset pin event |
| save_req | input | 1 | Power-save request |
| save_mode | input | 1 | 0 selects Sleep, 1 selects Idle |
| irq_en | input | NSRC | Per-source interrupt enables |
| irq_pend | input | NSRC | Per-source pending lines |
| irq_pri | input | NSRC*PW | Per-source priorities, source i at [PW*i +: PW] |
| cpu_pri | input | PW | Current core priority level |
| wdt_en | input | 1 | Watchdog enabled |
| wdt_to | input | 1 | Watchdog time-out pulse |
| osc_stable | input | 1 | Oscillator stable indication |
| clr_sleep | input | 1 | Write-one-to-clear strobe for st_sleep |
| clr_idle | input | 1 | Write-one-to-clear strobe for st_idle |
| clr_wdto | input | 1 | Write-one-to-clear strobe for st_wdto |
| cpu_clk_en | output | 1 | Core clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_en | output | 1 | Oscillator enable |
| wake_isr | output | 1 | One-cycle request to branch to the service routine |
| st_sleep | output | 1 | Sticky flag: a Sleep exit occurred |
| st_idle | output | 1 | Sticky flag: an Idle exit occurred |
| st_wdto | output | 1 | Sticky flag: a watchdog wake occurred |

## Verification
The assertions assume that `por` is held high for at least one edge before the other inputs matter, and that a clock enable can only rise from a state where the oscillator is running or after a reset event. The stimulus meets this by asserting `por` at the start and before each directed group. Every input changes one time unit after a rising edge and is held for whole cycles. The interrupt sweep covers every priority pair, both enable values and both modes, and computes the expected wake from the strict priority comparison. `osc_stable` is held low in Sleep until the bench has seen the wait state.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int NSRC = 4,
  parameter int PW   = 3
) (
  input  logic              clk,
  input  logic              por,
  input  logic              bor,
  input  logic              ext_rst,
  input  logic              save_req,
  input  logic              save_mode,
  input  logic [NSRC-1:0]   irq_en,
  input  logic [NSRC-1:0]   irq_pend,
  input  logic [NSRC*PW-1:0] irq_pri,
  input  logic [PW-1:0]     cpu_pri,
  input  logic              wdt_en,
  input  logic              wdt_to,
  input  logic              osc_stable,
  input  logic              clr_sleep,
  input  logic              clr_idle,
  input  logic              clr_wdto,
  output logic              cpu_clk_en,
  output logic              per_clk_en,
  output logic              osc_en,
  output logic              wake_isr,
  output logic              st_sleep,
  output logic              st_idle,
  output logic              st_wdto
);

  typedef enum logic [1:0] {S_RUN, S_SLP, S_IDL, S_SWAIT} pstate_t;

  pstate_t state, nxt;
  logic [NSRC-1:0] hit;
  logic irq_wake, wdt_wake, warm_rst;
  logic isr_pend, nxt_pend, nxt_isr;
  logic set_s, set_i, set_w;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    assign hit[i] = irq_en[i] & irq_pend[i] & (irq_pri[i*PW +: PW] > cpu_pri);
  end

  assign irq_wake = |hit;
  assign wdt_wake = wdt_en & wdt_to;
  assign warm_rst = bor | ext_rst;

  always_comb begin
    nxt      = state;
    nxt_pend = isr_pend;
    nxt_isr  = 1'b0;
    set_s    = 1'b0;
    set_i    = 1'b0;
    set_w    = 1'b0;
    case (state)
      S_RUN: if (!warm_rst && save_req) nxt = save_mode ? S_IDL : S_SLP;
      S_SLP: begin
        if (warm_rst) begin
          nxt = S_RUN; set_s = 1'b1; nxt_pend = 1'b0;
        end else if (wdt_wake) begin
          nxt = S_SWAIT; set_s = 1'b1; set_w = 1'b1; nxt_pend = 1'b0;
        end else if (irq_wake) begin
          nxt = S_SWAIT; set_s = 1'b1; nxt_pend = 1'b1;
        end
      end
      S_IDL: begin
        if (warm_rst) begin
          nxt = S_RUN; set_i = 1'b1;
        end else if (wdt_wake) begin
          nxt = S_RUN; set_i = 1'b1; set_w = 1'b1;
        end else if (irq_wake) begin
          nxt = S_RUN; set_i = 1'b1; nxt_isr = 1'b1;
        end
      end
      default: begin
        if (warm_rst) begin
          nxt = S_RUN; set_s = 1'b1; nxt_pend = 1'b0;
        end else if (osc_stable) begin
          nxt = S_RUN; nxt_isr = isr_pend; nxt_pend = 1'b0;
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (por) begin
      state    <= S_RUN;
      isr_pend <= 1'b0;
      wake_isr <= 1'b0;
      st_sleep <= 1'b0;
      st_idle  <= 1'b0;
      st_wdto  <= 1'b0;
    end else begin
      state    <= nxt;
      isr_pend <= nxt_pend;
      wake_isr <= nxt_isr;
      st_sleep <= set_s | (st_sleep & ~clr_sleep);
      st_idle  <= set_i | (st_idle & ~clr_idle);
      st_wdto  <= set_w | (st_wdto & ~clr_wdto);
    end
  end

  assign cpu_clk_en = (state == S_RUN);
  assign per_clk_en = (state == S_RUN) || (state == S_IDL);
  assign osc_en     = (state != S_SLP);

  // R2
  sleep_gate_chk: assert property (@(posedge clk) disable iff (por)
    (cpu_clk_en && save_req && !save_mode && !bor && !ext_rst) |=> (!cpu_clk_en && !per_clk_en && !osc_en));

  // R3
  idle_osc_chk: assert property (@(posedge clk) disable iff (por)
    (!cpu_clk_en && per_clk_en) |-> osc_en);

  // R7
  osc_wait_chk: assert property (@(posedge clk) disable iff (por)
    $rose(cpu_clk_en) |-> $past(per_clk_en || osc_stable || bor || ext_rst));

  // R11
  isr_pulse_chk: assert property (@(posedge clk) disable iff (por)
    wake_isr |-> (cpu_clk_en && !$past(cpu_clk_en)));

  // R8
  wdto_cause_chk: assert property (@(posedge clk) disable iff (por)
    $rose(st_wdto) |-> $past(wdt_en && wdt_to && !wake_isr));

  // R10
  sleep_sticky_chk: assert property (@(posedge clk) disable iff (por)
    (st_sleep && !clr_sleep) |=> st_sleep);

endmodule

// File: tb/pwr_mode_ctl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctl_tb;
  localparam int NSRC = 4;
  localparam int PW   = 3;

  logic clk = 1'b0;
  logic por = 1'b1, bor = 1'b0, ext_rst = 1'b0, save_req = 1'b0, save_mode = 1'b0;
  logic [NSRC-1:0] irq_en = '0, irq_pend = '0;
  logic [NSRC*PW-1:0] irq_pri = '0;
  logic [PW-1:0] cpu_pri = '0;
  logic wdt_en = 1'b0, wdt_to = 1'b0, osc_stable = 1'b0;
  logic clr_sleep = 1'b0, clr_idle = 1'b0, clr_wdto = 1'b0;
  logic cpu_clk_en, per_clk_en, osc_en, wake_isr, st_sleep, st_idle, st_wdto;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctl #(.NSRC(NSRC), .PW(PW)) u_dut (
    .clk(clk), .por(por), .bor(bor), .ext_rst(ext_rst), .save_req(save_req),
    .save_mode(save_mode), .irq_en(irq_en), .irq_pend(irq_pend), .irq_pri(irq_pri),
    .cpu_pri(cpu_pri), .wdt_en(wdt_en), .wdt_to(wdt_to), .osc_stable(osc_stable),
    .clr_sleep(clr_sleep), .clr_idle(clr_idle), .clr_wdto(clr_wdto),
    .cpu_clk_en(cpu_clk_en), .per_clk_en(per_clk_en), .osc_en(osc_en),
    .wake_isr(wake_isr), .st_sleep(st_sleep), .st_idle(st_idle), .st_wdto(st_wdto));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // expected vector order: cpu, per, osc, isr, sleep, idle, wdto
  task automatic chk(input string req, input logic [6:0] exp);
    logic [6:0] act;
    act = {cpu_clk_en, per_clk_en, osc_en, wake_isr, st_sleep, st_idle, st_wdto};
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic do_por();
    por = 1'b1; step(); por = 1'b0;
  endtask

  task automatic enter(input logic m);
    save_mode = m; save_req = 1'b1; step(); save_req = 1'b0;
  endtask

  task automatic clr_all();
    clr_sleep = 1'b1; clr_idle = 1'b1; clr_wdto = 1'b1; step();
    clr_sleep = 1'b0; clr_idle = 1'b0; clr_wdto = 1'b0;
  endtask

  initial begin
    step();
    por = 1'b0;
    chk("R1", 7'b1110000);

    // interrupt sweep: both modes, enable, every priority pair
    for (int m = 0; m < 2; m++)
      for (int en = 0; en < 2; en++)
        for (int p = 0; p < 8; p++)
          for (int c = 0; c < 8; c++) begin
            int s;
            bit w;
            s = (p + c) % NSRC;
            w = (en == 1) && (p > c);
            cpu_pri = PW'(c);
            irq_pri = '1;
            irq_pri[s*PW +: PW] = PW'(p);
            enter(m[0]);
            chk(m ? "R3" : "R2", m ? 7'b0110000 : 7'b0000000);
            irq_pend = '1; irq_en = '0; irq_en[s] = en[0];
            step();
            irq_pend = '0; irq_en = '0;
            if (w && m == 1) begin
              chk("R5 idle wake", 7'b1111010);
              step();
              chk("R11", 7'b1110010);
              clr_all();
              chk("R10", 7'b1110000);
            end else if (w) begin
              chk("R7 wait", 7'b0010100);
              step();
              chk("R7 hold", 7'b0010100);
              osc_stable = 1'b1; step(); osc_stable = 1'b0;
              chk("R7 resume", 7'b1111100);
              step();
              chk("R11", 7'b1110100);
              clr_all();
              chk("R10", 7'b1110000);
            end else begin
              chk("R6", m ? 7'b0110000 : 7'b0000000);
              ext_rst = 1'b1; step(); ext_rst = 1'b0;
              chk("R9", m ? 7'b1110010 : 7'b1110100);
              clr_all();
            end
          end
    cpu_pri = '0; irq_pri = '1;

    // R4: request outside Run ignored
    do_por();
    enter(1'b1);
    enter(1'b0);
    chk("R4", 7'b0110000);
    bor = 1'b1; step(); bor = 1'b0;
    chk("R9 bor idle", 7'b1110010);
    bor = 1'b1; step(); bor = 1'b0;
    chk("R9 bor in run", 7'b1110010);

    // R8: watchdog disabled ignored, then watchdog beats irq in Sleep
    do_por();
    enter(1'b0);
    wdt_to = 1'b1; step(); wdt_to = 1'b0;
    chk("R8 disabled", 7'b0000000);
    wdt_en = 1'b1; wdt_to = 1'b1; irq_en = 4'b0001; irq_pend = 4'b0001;
    step();
    wdt_to = 1'b0; irq_en = '0; irq_pend = '0;
    chk("R8 sleep", 7'b0010101);
    osc_stable = 1'b1; step(); osc_stable = 1'b0;
    chk("R8 no isr", 7'b1110101);

    // R8 in Idle
    do_por();
    enter(1'b1);
    wdt_to = 1'b1; irq_en = 4'b0010; irq_pend = 4'b0010;
    step();
    wdt_to = 1'b0; wdt_en = 1'b0; irq_en = '0; irq_pend = '0;
    chk("R8 idle", 7'b1110011);
    step();
    chk("R10 sticky", 7'b1110011);
    clr_wdto = 1'b1; step(); clr_wdto = 1'b0;
    chk("R10 wdto clear", 7'b1110010);

    // R10: set beats same-cycle clear
    enter(1'b1);
    irq_en = 4'b0100; irq_pend = 4'b0100; clr_idle = 1'b1;
    step();
    irq_en = '0; irq_pend = '0; clr_idle = 1'b0;
    chk("R10 set wins", 7'b1111010);

    // R9: warm reset from Sleep wait state
    do_por();
    enter(1'b0);
    irq_en = 4'b1000; irq_pend = 4'b1000; step(); irq_en = '0; irq_pend = '0;
    chk("R7 wait", 7'b0010100);
    ext_rst = 1'b1; step(); ext_rst = 1'b0;
    chk("R9 from wait", 7'b1110100);
    step();
    chk("R9 no isr", 7'b1110100);

    // R1: power-on reset from Idle clears everything
    enter(1'b1);
    do_por();
    chk("R1 from idle", 7'b1110000);

    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule